// File: doc/BRIEF.md
# Receive Buffer with Interrupt Status

This block holds received packet bytes in a small first-in first-out store and summarises the state of reception in an 8-bit status byte that a host can read at any time. A packet-receive engine on one side pushes data bytes and signals the start of a packet, its end (with a good or failed check), and other reception faults. A host on the other side pops bytes, reads the status byte (clearing the event flags that clear on read), writes it (clearing the overwrite flag), and loads an 8-bit enable mask.

The status byte mixes two kinds of flag. Three level flags track the buffer occupancy from cycle to cycle. Five sticky event flags each have their own clear rule: clear on a status read, clear on any status write, or clear only after a receive-go command followed by a start-of-packet. When a start-of-packet arrives while unread bytes remain, the block either drops the new packet and reports a receive error, or, in overwrite mode, discards the old bytes and raises the overwrite flag. A single interrupt line is high while any enabled status bit is set.

Top module: `rxbuf_irq`

## Requirements
- R1: After reset the buffer is empty, `host_data` is 0x00, every status bit is 0, the enable mask is 0 and `irq` is 0.
- R2: `stat_data` bit positions are fixed: bit 7 overwrite, bit 6 start-of-packet seen, bit 5 full, bit 4 half full, bit 3 not empty, bit 2 buffer error, bit 1 packet complete, bit 0 receive error.
- R3: Bytes leave in the order they were accepted; `host_data` shows the oldest byte combinationally, shows 0x00 when the buffer is empty, and a pop of an empty buffer removes nothing.
- R4: The full flag is 1 exactly when 16 bytes are held, the half-full flag is 1 when 8 or more are held, and the not-empty flag is 1 when at least one is held, each following the occupancy in the cycle after it changes.
- R5: The buffer-error flag sets on a pop of an empty buffer or on a push into a full buffer (judged on the occupancy at the start of the cycle; the byte is dropped). It stays set through status reads and writes and clears only on a start-of-packet in or after the cycle of a receive-go command.
- R6: Packet complete sets on a good end-of-packet outside a dropped packet; receive error sets on a bad check, an early end, a type mismatch, or a dropped packet. These two flags and the start-of-packet flag (set on every start-of-packet) clear on a status read, except that a set event in the same cycle as the read leaves the flag at 1.
- R7: With overwrite mode off, a start-of-packet while bytes are held drops the new packet: receive error sets and pushes are ignored until the next start-of-packet or end-of-packet indication.
- R8: With overwrite mode on, a start-of-packet while bytes are held empties the buffer (a pop or push in that cycle is ignored) and sets the overwrite flag, which clears on any status write; with overwrite mode off the flag never sets.
- R9: `irq` is 1 exactly when some status bit and the mask bit at the same position are both 1; the mask is loaded by `mask_wr`, and status bits update whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Engine pushes `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| rx_sop | input | 1 | Start of packet seen |
| rx_eop_ok | input | 1 | Packet ended with good check |
| rx_eop_crc_bad | input | 1 | Packet ended with failed check |
| rx_eop_early | input | 1 | Unexpected end of packet |
| rx_type_bad | input | 1 | Packet type mismatch |
| rx_go | input | 1 | Receive-go command pulse |
| ovw_mode | input | 1 | Overwrite mode enable |
| host_pop | input | 1 | Host removes the oldest byte |
| host_data | output | 8 | Oldest byte, 0x00 when empty |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| stat_wr | input | 1 | Status write strobe (value ignored) |
| stat_data | output | 8 | Status byte |
| mask_wr | input | 1 | Load the enable mask |
| mask_wdata | input | 8 | New enable mask |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong occupancy count shows on the level flags and on `host_data` in the very next cycle, and a wrong pointer shows as an out-of-order byte at the next pop. A sticky flag that clears on the wrong strobe, or a lost same-cycle event, shows on `stat_data` and `irq` one cycle after the read or write. A wrong drop or overwrite decision shows as the wrong receive-error or overwrite bit one cycle after the start-of-packet and as wrong `host_data` at the following pops.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    // Status byte bit positions (host software decodes these)
    localparam int ST_OVW  = 7;
    localparam int ST_SOP  = 6;
    localparam int ST_FULL = 5;
    localparam int ST_HALF = 4;
    localparam int ST_NEMP = 3;
    localparam int ST_BERR = 2;
    localparam int ST_CMPL = 1;
    localparam int ST_RERR = 0;
    localparam int ST_W    = 8;

    typedef struct packed {
        logic ovw;
        logic sop;
        logic berr;
        logic cmpl;
        logic rerr;
    } evt_flags_t;

    typedef struct packed {
        logic full;
        logic half;
        logic nemp;
    } lvl_flags_t;

    function automatic logic [ST_W-1:0] pack_status(evt_flags_t e, lvl_flags_t l);
        logic [ST_W-1:0] s;
        s          = '0;
        s[ST_OVW]  = e.ovw;
        s[ST_SOP]  = e.sop;
        s[ST_FULL] = l.full;
        s[ST_HALF] = l.half;
        s[ST_NEMP] = l.nemp;
        s[ST_BERR] = e.berr;
        s[ST_CMPL] = e.cmpl;
        s[ST_RERR] = e.rerr;
        return s;
    endfunction

endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output lvl_flags_t    lvl,
    output logic          push_lost,
    output logic          pop_miss
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          is_full, is_empty, acc_push, acc_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full   = (count == CW'(DEPTH));
    assign is_empty  = (count == '0);
    assign acc_push  = push && !flush && !is_full;
    assign acc_pop   = pop  && !flush && !is_empty;
    assign push_lost = push && !flush && is_full;
    assign pop_miss  = pop  && !flush && is_empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc_push) wr_ptr <= bump(wr_ptr);
            if (acc_pop)  rd_ptr <= bump(rd_ptr);
            case ({acc_push, acc_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (acc_push) mem[wr_ptr] <= din;
    end

    assign dout     = is_empty ? '0 : mem[rd_ptr];
    assign lvl.full = is_full;
    assign lvl.half = (count >= CW'(HALF));
    assign lvl.nemp = !is_empty;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R4
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && is_empty) |=> is_empty); // R3
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && is_full) |=> is_full); // R5

endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags
    import rxbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_flags_t set,
    input  logic       rd_clr,
    input  logic       wr_clr,
    input  logic       sop,
    input  logic       go,
    output evt_flags_t flags
);
    logic armed;
    logic berr_clr;

    assign berr_clr = sop && (armed || go);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            armed <= 1'b0;
        end else begin
            flags.sop  <= set.sop  | (flags.sop  & ~rd_clr);
            flags.cmpl <= set.cmpl | (flags.cmpl & ~rd_clr);
            flags.rerr <= set.rerr | (flags.rerr & ~rd_clr);
            flags.ovw  <= set.ovw  | (flags.ovw  & ~wr_clr);
            flags.berr <= set.berr | (flags.berr & ~berr_clr);
            armed      <= (armed | go) & ~sop;
        end
    end

    AST_BERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.berr && !sop) |=> flags.berr); // R5
    AST_CMPL_WINS: assert property (@(posedge clk) disable iff (rst)
        set.cmpl |=> flags.cmpl); // R6
    AST_RERR_WINS: assert property (@(posedge clk) disable iff (rst)
        (set.rerr && rd_clr) |=> flags.rerr); // R6

endmodule

// File: rtl/rxbuf_irqgen.sv
module rxbuf_irqgen
    import rxbuf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [ST_W-1:0] wdata,
    input  logic [ST_W-1:0] status,
    output logic            irq
);
    logic [ST_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst)     mask <= '0;
        else if (wr) mask <= wdata;
    end

    assign irq = |(status & mask);

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(wr && (wdata == '0)) |-> !irq); // R9
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0)); // R9

endmodule

// File: rtl/rxbuf_irq.sv
module rxbuf_irq
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_sop,
    input  logic            rx_eop_ok,
    input  logic            rx_eop_crc_bad,
    input  logic            rx_eop_early,
    input  logic            rx_type_bad,
    input  logic            rx_go,
    input  logic            ovw_mode,
    input  logic            host_pop,
    output logic [DW-1:0]   host_data,
    input  logic            stat_rd,
    input  logic            stat_wr,
    output logic [ST_W-1:0] stat_data,
    input  logic            mask_wr,
    input  logic [ST_W-1:0] mask_wdata,
    output logic            irq
);
    lvl_flags_t lvl;
    evt_flags_t ev_set, ev_q;
    logic       dropping, flush, drop_start, any_eop;
    logic       push_lost, pop_miss;

    assign flush      = rx_sop && lvl.nemp &&  ovw_mode;
    assign drop_start = rx_sop && lvl.nemp && !ovw_mode;
    assign any_eop    = rx_eop_ok || rx_eop_crc_bad || rx_eop_early;

    always_ff @(posedge clk) begin
        if (rst)                      dropping <= 1'b0;
        else if (drop_start)          dropping <= 1'b1;
        else if (rx_sop || any_eop)   dropping <= 1'b0;
    end

    always_comb begin
        ev_set.ovw  = flush;
        ev_set.sop  = rx_sop;
        ev_set.berr = push_lost || pop_miss;
        ev_set.cmpl = rx_eop_ok && !dropping;
        ev_set.rerr = rx_eop_crc_bad || rx_eop_early || rx_type_bad || drop_start;
    end

    rxbuf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push && !dropping),
        .din       (rx_data),
        .pop       (host_pop),
        .flush     (flush),
        .dout      (host_data),
        .lvl       (lvl),
        .push_lost (push_lost),
        .pop_miss  (pop_miss)
    );

    rxbuf_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .set    (ev_set),
        .rd_clr (stat_rd),
        .wr_clr (stat_wr),
        .sop    (rx_sop),
        .go     (rx_go),
        .flags  (ev_q)
    );

    assign stat_data = pack_status(ev_q, lvl);

    rxbuf_irqgen u_irq (
        .clk    (clk),
        .rst    (rst),
        .wr     (mask_wr),
        .wdata  (mask_wdata),
        .status (stat_data),
        .irq    (irq)
    );

    AST_OVW_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_data[ST_OVW]) |-> $past(ovw_mode)); // R8
    AST_DROP_SETS_RERR: assert property (@(posedge clk) disable iff (rst)
        drop_start |=> stat_data[ST_RERR]); // R7

endmodule

// File: tb/rxbuf_irq_test.sv
module rxbuf_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0, rst = 1'b1;
    logic       rx_push = 0, rx_sop = 0, rx_eop_ok = 0, rx_eop_crc_bad = 0;
    logic       rx_eop_early = 0, rx_type_bad = 0, rx_go = 0, ovw_mode = 0;
    logic       host_pop = 0, stat_rd = 0, stat_wr = 0, mask_wr = 0;
    logic [7:0] rx_data = 0, mask_wdata = 0;
    logic [7:0] host_data, stat_data;
    logic       irq;

    rxbuf_irq uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;

    // Bench model
    logic [7:0] m_q[$];
    bit m_ovw, m_sopf, m_berr, m_cmpl, m_rerr, m_armed, m_drop;
    logic [7:0] m_mask;

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s[7] = m_ovw;  s[6] = m_sopf;
        s[5] = (m_q.size() == DEPTH);
        s[4] = (m_q.size() >= DEPTH/2);
        s[3] = (m_q.size() != 0);
        s[2] = m_berr; s[1] = m_cmpl; s[0] = m_rerr;
        return s;
    endfunction

    function automatic string bit_req(int b);
        case (b)
            7: return "R8";
            6, 1, 0: return "R6";
            5, 4, 3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        logic [7:0] s;
        s = exp_status();
        for (int b = 0; b < 8; b++)
            chk(bit_req(b), $sformatf("R2 status bit %0d", b), 8'(stat_data[b]), 8'(s[b]));
        chk("R3", "host_data", host_data, (m_q.size() != 0) ? m_q[0] : 8'h00);
        chk("R9", "irq", 8'(irq), 8'(|(s & m_mask)));
    endtask

    task automatic model_update();
        int  sz = m_q.size();
        bit  flush = rx_sop && sz != 0 && ovw_mode;
        bit  dstart = rx_sop && sz != 0 && !ovw_mode;
        bit  pushi = rx_push && !m_drop;
        bit  pf = 0, ef = 0;
        bit  any_eop = rx_eop_ok || rx_eop_crc_bad || rx_eop_early;
        bit  bclr, cset, rset;
        if (flush) m_q.delete();
        else begin
            pf = pushi && sz == DEPTH;
            ef = host_pop && sz == 0;
            if (host_pop && sz > 0) void'(m_q.pop_front());
            if (pushi && sz < DEPTH) m_q.push_back(rx_data);
        end
        bclr = rx_sop && (m_armed || rx_go);
        cset = rx_eop_ok && !m_drop;
        rset = rx_eop_crc_bad || rx_eop_early || rx_type_bad || dstart;
        m_berr  = (pf || ef) ? 1'b1 : (bclr ? 1'b0 : m_berr);
        m_armed = (m_armed || rx_go) && !rx_sop;
        m_sopf  = rx_sop ? 1'b1 : (stat_rd ? 1'b0 : m_sopf);
        m_cmpl  = cset ? 1'b1 : (stat_rd ? 1'b0 : m_cmpl);
        m_rerr  = rset ? 1'b1 : (stat_rd ? 1'b0 : m_rerr);
        m_ovw   = flush ? 1'b1 : (stat_wr ? 1'b0 : m_ovw);
        m_drop  = dstart ? 1'b1 : ((rx_sop || any_eop) ? 1'b0 : m_drop);
        if (mask_wr) m_mask = mask_wdata;
    endtask

    // Inputs are set at a negedge by the caller; this checks, clocks, models, clears.
    task automatic cyc();
        #1;
        check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
        {rx_push, rx_sop, rx_eop_ok, rx_eop_crc_bad, rx_eop_early, rx_type_bad} = '0;
        {rx_go, host_pop, stat_rd, stat_wr, mask_wr} = '0;
    endtask

    task automatic push_b(logic [7:0] b); rx_push = 1; rx_data = b; cyc(); endtask
    task automatic pop1();  host_pop = 1; cyc(); endtask
    task automatic sop1();  rx_sop = 1; cyc(); endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        m_mask = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        #1;
        chk("R1", "reset status", stat_data, 8'h00);
        chk("R1", "reset irq", 8'(irq), 8'h00);
        chk("R1", "reset host_data", host_data, 8'h00);
        // R9 mask loads
        mask_wr = 1; mask_wdata = 8'hFF; cyc();
        // R4/R3 fill to full, R5 overflow
        for (int i = 0; i < DEPTH; i++) push_b(8'(i * 7 + 1));
        push_b(8'hEE);
        chk("R5", "berr after overflow", 8'(stat_data[2]), 8'h01);
        stat_rd = 1; stat_wr = 1; cyc();
        chk("R5", "berr survives rd/wr", 8'(stat_data[2]), 8'h01);
        for (int i = 0; i < DEPTH; i++) pop1();
        pop1();  // R3 empty pop
        chk("R3", "empty host_data", host_data, 8'h00);
        sop1();  // no go yet: R5 berr stays
        chk("R5", "berr kept without go", 8'(stat_data[2]), 8'h01);
        rx_go = 1; cyc();
        sop1();
        chk("R5", "berr cleared by go+sop", 8'(stat_data[2]), 8'h00);
        // R6 read with simultaneous event
        rx_eop_ok = 1; stat_rd = 1; cyc();
        chk("R6", "cmpl wins over read", 8'(stat_data[1]), 8'h01);
        stat_rd = 1; cyc();
        chk("R6", "cmpl cleared", 8'(stat_data[1]), 8'h00);
        // R7 drop
        push_b(8'h11); push_b(8'h22); push_b(8'h33);
        sop1();
        chk("R7", "rerr on drop", 8'(stat_data[0]), 8'h01);
        push_b(8'h44); push_b(8'h55);
        rx_eop_ok = 1; cyc();
        chk("R7", "no cmpl in dropped packet", 8'(stat_data[1]), 8'h00);
        pop1(); pop1();
        chk("R7", "dropped bytes absent", host_data, 8'h33);
        pop1();
        // R8 overwrite
        ovw_mode = 1; push_b(8'hA1); push_b(8'hA2);
        sop1();
        chk("R8", "ovw set", 8'(stat_data[7]), 8'h01);
        chk("R8", "buffer emptied", host_data, 8'h00);
        stat_wr = 1; cyc();
        chk("R8", "ovw cleared by write", 8'(stat_data[7]), 8'h00);
        // R9 mask off
        mask_wr = 1; mask_wdata = 8'h00; rx_type_bad = 1; cyc();
        chk("R9", "irq masked", 8'(irq), 8'h00);
        // Random phases
        void'($urandom(32'h5EED_1234));
        for (int ph = 0; ph < 4; ph++) begin
            ovw_mode = ph[0];
            for (int n = 0; n < 3000; n++) begin
                int r = $urandom_range(0, 99);
                int pp = (ph < 2) ? 60 : 35;
                if (r < 6 && !rx_push) begin
                    rx_sop = 1;
                end else begin
                    rx_push  = ($urandom_range(0, 99) < pp);
                    rx_data  = 8'($urandom);
                    host_pop = ($urandom_range(0, 99) < 100 - pp);
                end
                rx_eop_ok      = ($urandom_range(0, 99) < 4);
                rx_eop_crc_bad = ($urandom_range(0, 99) < 2);
                rx_eop_early   = ($urandom_range(0, 99) < 1);
                rx_type_bad    = ($urandom_range(0, 99) < 1);
                rx_go          = ($urandom_range(0, 99) < 5);
                stat_rd        = ($urandom_range(0, 99) < 8);
                stat_wr        = ($urandom_range(0, 99) < 5);
                mask_wr        = ($urandom_range(0, 99) < 3);
                mask_wdata     = 8'($urandom);
                cyc();
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule